// File: doc/BRIEF.md
# Level-Sensitive DMA Request Acceptor

This block is the front end of one external DMA channel. It watches an active-low request pin, holds a pending request once a low level is seen, obtains the bus from an arbiter through a request/grant handshake, and then steps a transfer sequencer through activation, read, write and dead phases in block-transfer mode. Each phase lasts one clock. The block exposes its phase as a state code. Address generation, data steering and external memory timing are not part of it.

Software enables the channel with a one-cycle enable strobe. The strobe carries a block length, which is the number of read/write pairs, and a block count. Request sampling is gated by an acceptance window. The window opens on the enable, closes as soon as a request is held, and opens again only once the dead cycle after a block has ended. A pin held low therefore starts exactly one block per window. During the read and write phases an acknowledge output marks the access, as single-address transfers need. After the last block the block raises a one-cycle done pulse and disables itself.

Top module: `dma_req_acceptor`

## Requirements
- R1: While and after reset, `bus_req`, `xfer_ack` and `done` are low and `phase` is 0 (idle). Phase codes: 0 idle, 1 arbitration, 2 activation, 3 read, 4 write, 5 dead.
- R2: Before an accepted enable, a low `req_n` has no effect. An `en_wr` strobe is ignored when `blk_size` or `xfer_cnt` is zero, or when the channel is already enabled.
- R3: `req_n` is first sampled at the clock edge after the edge that takes the enable. A low level sampled there is held, and `phase` becomes 1 at the following edge. A request is held only while the window is open.
- R4: `bus_req` is high in phases 1 to 4. Phase 1 persists while `bus_gnt` is low. A grant moves to phase 2 for exactly one cycle, and phase 3 follows.
- R5: One accepted request runs `blk_size` read/write pairs (3,4,3,4,...) and then phase 5. `xfer_ack` is high exactly in phases 3 and 4.
- R6: `bus_req` is low in phase 5, and the window reopens only when phase 5 ends. With `req_n` held high the channel then stays idle. With `req_n` held low and grant high, blocks repeat every 2*`blk_size`+5 cycles.
- R7: After `xfer_cnt` blocks, `done` is high for exactly the one cycle after the final phase 5. The channel then disables itself, so a low `req_n` starts nothing.
- R8: Activation clears the held request. The window and the held request are never both set.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | 1 | Active-low external transfer request |
| en_wr | input | 1 | One-cycle strobe writing the channel enable |
| blk_size | input | BLK_W | Read/write pairs per block, taken at enable |
| xfer_cnt | input | CNT_W | Number of blocks, taken at enable |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| xfer_ack | output | 1 | Acknowledge to the external device during access |
| done | output | 1 | One-cycle pulse after the last block |
| phase | output | 3 | Current sequencer phase code |

## Verification
A window that stays open or reopens too early shows up as an extra arbitration phase or a shorter block period within a few cycles of phase 5, so the bench times each full transfer to the exact cycle. A wrong beat or block counter shows up as a read/write count or a done pulse off by whole pairs or blocks, which is visible by the end of the transfer. A stuck grant wait, acknowledge or bus request misfires in the same cycle as the phase code, and the bench checks every cycle of the sweep for it.

// File: rtl/dra_pkg.sv
package dra_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ARB  = 3'd1,
    PH_ACT  = 3'd2,
    PH_RD   = 3'd3,
    PH_WR   = 3'd4,
    PH_DEAD = 3'd5
  } phase_t;

  // true when a down-counter holds its final unit
  function automatic logic one_left(input int unsigned v);
    return v == 1;
  endfunction

  // cycles between block starts with request low and grant high
  function automatic int unsigned block_period(input int unsigned pairs);
    return 2 * pairs + 5;
  endfunction

  // data phases that drive the acknowledge
  function automatic logic is_access(input phase_t p);
    return (p == PH_RD) || (p == PH_WR);
  endfunction

endpackage

// File: rtl/dra_accept.sv
module dra_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic open_evt,
  input  logic reopen_evt,
  input  logic clear_evt,
  output logic acc_open,
  output logic pend
);

  logic take;
  assign take = acc_open && !req_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_open <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (open_evt || reopen_evt) acc_open <= 1'b1;
      else if (take)              acc_open <= 1'b0;
      if (take)           pend <= 1'b1;
      else if (clear_evt) pend <= 1'b0;
    end
  end

  // R8
  window_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_open && pend));

  // R3
  latch_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(acc_open));

endmodule

// File: rtl/dra_counters.sv
module dra_counters #(
  parameter int BLK_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] blk_size,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic             beat_load,
  input  logic             beat_step,
  input  logic             blk_step,
  output logic             last_beat,
  output logic             last_blk
);
  import dra_pkg::*;

  localparam logic [BLK_W-1:0] BEAT_ONE = BLK_W'(1);
  localparam logic [CNT_W-1:0] BLK_ONE  = CNT_W'(1);

  logic [BLK_W-1:0] len_q, beat_q;
  logic [CNT_W-1:0] blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      beat_q <= '0;
      blk_q  <= '0;
    end else begin
      if (load) begin
        len_q <= blk_size;
        blk_q <= xfer_cnt;
      end else if (blk_step) begin
        blk_q <= blk_q - BLK_ONE;
      end
      if (beat_load)      beat_q <= len_q;
      else if (beat_step) beat_q <= beat_q - BEAT_ONE;
    end
  end

  assign last_beat = one_left(32'(beat_q));
  assign last_blk  = one_left(32'(blk_q));

endmodule

// File: rtl/dra_seq.sv
module dra_seq (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pend,
  input  logic            bus_gnt,
  input  logic            last_beat,
  input  logic            last_blk,
  output dra_pkg::phase_t state,
  output logic            bus_req,
  output logic            xfer_ack,
  output logic            act_evt,
  output logic            wr_evt,
  output logic            dead_evt,
  output logic            finish_evt,
  output logic            reopen_evt,
  output logic            done
);
  import dra_pkg::*;

  phase_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PH_IDLE: if (pend) nxt = PH_ARB;
      PH_ARB:  if (bus_gnt) nxt = PH_ACT;
      PH_ACT:  nxt = PH_RD;
      PH_RD:   nxt = PH_WR;
      PH_WR:   nxt = last_beat ? PH_DEAD : PH_RD;
      PH_DEAD: nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish_evt;
    end
  end

  assign act_evt    = (state == PH_ACT);
  assign wr_evt     = (state == PH_WR);
  assign dead_evt   = (state == PH_DEAD);
  assign finish_evt = dead_evt && last_blk;
  assign reopen_evt = dead_evt && !last_blk;
  assign bus_req    = (state == PH_ARB) || (state == PH_ACT) || is_access(state);
  assign xfer_ack   = is_access(state);

  // R4
  grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_ARB && !bus_gnt) |=> (state == PH_ARB));

  // R4
  act_to_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_ACT) |=> (state == PH_RD));

  // R6
  dead_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_DEAD) |-> !bus_req);

  // R5
  ack_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> bus_req);

  // R7
  done_after_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state) == PH_DEAD) && (state == PH_IDLE));

endmodule

// File: rtl/dma_req_acceptor.sv
module dma_req_acceptor #(
  parameter int BLK_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_n,
  input  logic             en_wr,
  input  logic [BLK_W-1:0] blk_size,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             xfer_ack,
  output logic             done,
  output logic [2:0]       phase
);
  import dra_pkg::*;

  logic   en_q, en_accept;
  logic   acc_open, pend;
  logic   act_evt, wr_evt, dead_evt, finish_evt, reopen_evt;
  logic   last_beat, last_blk;
  phase_t state;

  // R2: enable taken only when idle-disabled and both sizes are nonzero
  assign en_accept = en_wr && !en_q && (|blk_size) && (|xfer_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)          en_q <= 1'b0;
    else if (en_accept)  en_q <= 1'b1;
    else if (finish_evt) en_q <= 1'b0;
  end

  dra_accept u_accept (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n      (req_n),
    .open_evt   (en_accept),
    .reopen_evt (reopen_evt),
    .clear_evt  (act_evt),
    .acc_open   (acc_open),
    .pend       (pend)
  );

  dra_counters #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_counters (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (en_accept),
    .blk_size  (blk_size),
    .xfer_cnt  (xfer_cnt),
    .beat_load (act_evt),
    .beat_step (wr_evt),
    .blk_step  (dead_evt),
    .last_beat (last_beat),
    .last_blk  (last_blk)
  );

  dra_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend),
    .bus_gnt    (bus_gnt),
    .last_beat  (last_beat),
    .last_blk   (last_blk),
    .state      (state),
    .bus_req    (bus_req),
    .xfer_ack   (xfer_ack),
    .act_evt    (act_evt),
    .wr_evt     (wr_evt),
    .dead_evt   (dead_evt),
    .finish_evt (finish_evt),
    .reopen_evt (reopen_evt),
    .done       (done)
  );

  assign phase = state;

  // R2
  closed_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!acc_open && !pend));

  // R8
  clear_on_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt |=> !pend);

endmodule

// File: tb/dma_req_acceptor_bench.sv
module dma_req_acceptor_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_n = 1'b1;
  logic       en_wr = 1'b0;
  logic [7:0] blk_size = 8'd0;
  logic [7:0] xfer_cnt = 8'd0;
  logic       bus_gnt = 1'b1;
  logic       bus_req, xfer_ack, done;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dma_req_acceptor u_dma_req_acceptor (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .en_wr(en_wr),
    .blk_size(blk_size), .xfer_cnt(xfer_cnt), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .xfer_ack(xfer_ack), .done(done), .phase(phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic enable(input int n, input int m);
    @(negedge clk);
    blk_size = 8'(n); xfer_cnt = 8'(m); en_wr = 1'b1;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic wait_done(input int limit, output int waited);
    waited = 0;
    while (!done && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  // full transfer with request held low, grant high; exact counts
  task automatic run_xfer(input int n, input int m, input bit poke);
    int cyc = 0, rd = 0, wr = 0, ak = 0, dd = 0, bad = 0;
    bit got = 0;
    int expc = m * (2 * n + 5);
    bus_gnt = 1'b1;
    req_n = 1'b0;
    enable(n, m);
    while (!got && cyc < 500) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin xfer_cnt = 8'd7; en_wr = 1'b1; end
      if (poke && cyc == 4) en_wr = 1'b0;
      if (phase == 3'd3) rd++;
      if (phase == 3'd4) wr++;
      if (phase == 3'd5) begin dd++; if (bus_req) bad++; end
      if (xfer_ack) ak++;
      if (xfer_ack != (phase == 3'd3 || phase == 3'd4)) bad++;
      if (done) got = 1;
    end
    // R6: block period 2n+5 per block; R2 busy enable ignored when poke
    chk(cyc == expc, "R6 transfer length", cyc, expc);
    chk(rd == n * m, "R5 read phases", rd, n * m);
    chk(wr == n * m, "R5 write phases", wr, n * m);
    chk(ak == 2 * n * m, "R5 ack cycles", ak, 2 * n * m);
    chk(dd == m, "R6 dead phases", dd, m);
    chk(bad == 0, "R5 ack/bus_req per-cycle mismatches", bad, 0);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    repeat (6) @(negedge clk);
    // R7: disabled, request still low
    chk(phase == 3'd0 && !bus_req, "R7 self-disable", phase, 0);
    req_n = 1'b1;
  endtask

  initial begin
    int k;
    bit seen;
    repeat (3) @(negedge clk);
    // R1
    chk(phase == 3'd0 && !bus_req && !xfer_ack && !done, "R1 in reset", phase, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phase == 3'd0 && !bus_req && !xfer_ack && !done, "R1 after reset", phase, 0);

    // R2: no enable, request low
    req_n = 1'b0;
    repeat (10) @(negedge clk);
    chk(phase == 3'd0 && !bus_req, "R2 before enable", phase, 0);
    // R2: zero count enable ignored
    enable(2, 0);
    repeat (8) @(negedge clk);
    chk(phase == 3'd0 && !bus_req, "R2 zero count", phase, 0);
    enable(0, 2);
    repeat (8) @(negedge clk);
    chk(phase == 3'd0 && !bus_req, "R2 zero block size", phase, 0);
    req_n = 1'b1;

    // sweep of block sizes and counts
    for (int n = 1; n <= 3; n++)
      for (int m = 1; m <= 3; m++)
        run_xfer(n, m, 1'b0);
    // R2: enable while busy ignored
    run_xfer(2, 1, 1'b1);

    // R3: sampling latency from enable
    req_n = 1'b0;
    bus_gnt = 1'b0;
    @(negedge clk);
    blk_size = 8'd1; xfer_cnt = 8'd1; en_wr = 1'b1;
    k = 0;
    while (phase != 3'd1 && k < 20) begin
      @(negedge clk);
      en_wr = 1'b0;
      k++;
    end
    chk(k == 3, "R3 enable to arbitration", k, 3);
    // R4: grant withheld
    repeat (8) @(negedge clk);
    chk(phase == 3'd1 && bus_req && !xfer_ack, "R4 wait for grant", phase, 1);
    bus_gnt = 1'b1;
    @(negedge clk);
    chk(phase == 3'd2 && bus_req, "R4 activation", phase, 2);
    @(negedge clk);
    chk(phase == 3'd3 && xfer_ack, "R4 read after activation", phase, 3);
    wait_done(20, k);
    chk(done == 1'b1, "R7 done after granted block", done, 1);
    req_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: one block per window; pin high keeps idle
    req_n = 1'b0;
    enable(1, 2);
    k = 0;
    while (phase != 3'd1 && k < 20) begin @(negedge clk); k++; end
    req_n = 1'b1;
    k = 0;
    while (phase != 3'd5 && k < 20) begin @(negedge clk); k++; end
    seen = 0;
    repeat (12) begin @(negedge clk); if (done) seen = 1; end
    chk(phase == 3'd0 && !bus_req, "R6 idle with pin high", phase, 0);
    chk(!seen, "R6 no extra block", seen, 0);
    // R3: low level to arbitration in two edges
    req_n = 1'b0;
    k = 0;
    while (phase != 3'd1 && k < 20) begin @(negedge clk); k++; end
    chk(k == 2, "R3 request to arbitration", k, 2);
    wait_done(20, k);
    chk(done == 1'b1, "R7 done after second window", done, 1);
    req_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule